// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a free-running reference clock enable into the 16x oversampling tick of a serial port. A CPU programs a 16-bit divisor through two byte-wide registers that are decoded only while the divisor access bit is high. The block then emits one tick for every divisor count of reference enables. With the usual 1.8432 MHz reference, divisor 12 gives 9600 bit/s, 96 gives 1200 bit/s and 384 gives 300 bit/s. Divisor 2 gives 56000 bit/s, about 2.86 percent off, and 857 gives 134.5 bit/s, about 0.058 percent off.

The counter counts down and reloads itself from the divisor. A write to either divisor byte reloads the counter in the same cycle, so a new rate takes effect at once and never waits out a long count left over from the old divisor. A copy of the tick can be driven onto a clock output pin, gated by a control bit.

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor is 0, and `tick_o` and `baud_clk_o` are low.
- R2: A write with `wr_en_i`=1 and `dlab_i`=1 stores `wr_data_i` into the low divisor byte at `addr_i`=0 or into the high divisor byte at `addr_i`=1. A write with `dlab_i`=0 changes neither byte and does not reload the counter.
- R3: With a divisor N>=2 and `ref_en_i` held high, `tick_o` is a one-cycle pulse every N clock cycles.
- R4: With divisor 1, `tick_o` pulses on every reference enable, so it stays high while `ref_en_i` is held high.
- R5: With divisor 0, `tick_o` never rises.
- R6: An accepted divisor write loads the counter with the new 16-bit value in the same cycle and gives no tick in the cycle after it. The first tick follows exactly N reference enables after the write.
- R7: The counter advances only in cycles with `ref_en_i`=1. `tick_o` is high in the clock cycle after the enable that completes a count.
- R8: `baud_clk_o` equals `tick_o` when `clk_out_en_i` was 1 in the enable cycle, and is low otherwise.
- R9: A write with `dlab_i`=1 to an `addr_i` of 2 or above changes no divisor byte and does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe |
| dlab_i | input | 1 | Divisor access bit; the divisor bytes decode only when it is 1 |
| addr_i | input | ADDR_W | Register offset: 0 selects the low byte, 1 the high byte |
| wr_data_i | input | 8 | Write data |
| ref_en_i | input | 1 | Reference clock enable, one cycle per reference period |
| clk_out_en_i | input | 1 | Control bit that drives the tick onto the clock pin |
| tick_o | output | 1 | 16x sample tick, one cycle wide |
| baud_clk_o | output | 1 | Gated copy of the tick for the clock pin |

## Verification
The bench measures the spacing of the ticks for several divisors: divisor 2, the common rates 12 and 96, and a value that needs the high byte. A design with the bytes swapped, or with an off-by-one reload, would show the wrong period. Divisors 1 and 0 are checked apart from the others, because a counter that tests only for a match at 1 either stalls or wraps at these values. For the reload case, the divisor is rewritten in the middle of a long count. A design that waits for the old count to run out would give its first tick hundreds of cycles late. Ignored writes, with the access bit clear or to a higher offset, and a reference enable active only every other cycle, must leave the period unchanged or doubled exactly.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OFS_DIV_LO = 2'd0,
    OFS_DIV_HI = 2'd1
  } div_ofs_e;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              dlab_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o,
  output logic [DIV_W-1:0]  load_val_o
);
  localparam int unsigned NB = DIV_W / BYTE_W;

  logic [NB-1:0]    sel;
  logic [DIV_W-1:0] div_q;

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign sel[b] = wr_en_i && dlab_i && (addr_i == ADDR_W'(b));
  end

  // value the divisor takes after this cycle's write
  always_comb begin
    load_val_o = div_q;
    for (int b = 0; b < NB; b++) begin
      if (sel[b]) load_val_o[b*BYTE_W +: BYTE_W] = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (|sel) div_q <= load_val_o;
  end

  assign load_o = |sel;
  assign div_o  = div_q;
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_en_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             hit_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run;

  assign run   = ref_en_i && (div_i != '0);
  // a reload takes priority and suppresses the tick
  assign hit_o = run && !load_i && (cnt_q <= DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run) begin
      if (cnt_q <= DIV_W'(1)) cnt_q <= div_i;
      else cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/baud_out_stage.sv
module baud_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clk_out_en_i,
  output logic tick_o,
  output logic baud_clk_o
);
  logic tick_q, clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      tick_q <= hit_i;
      clk_q  <= hit_i && clk_out_en_i;
    end
  end

  assign tick_o     = tick_q;
  assign baud_clk_o = clk_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              dlab_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              ref_en_i,
  input  logic              clk_out_en_i,
  output logic              tick_o,
  output logic              baud_clk_o
);
  logic [DIV_W-1:0] div_q, load_val, cnt_q;
  logic             load, hit;

  baud_div_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .dlab_i    (dlab_i),
    .addr_i    (addr_i),
    .data_i    (wr_data_i),
    .div_o     (div_q),
    .load_o    (load),
    .load_val_o(load_val)
  );

  baud_down_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_en_i  (ref_en_i),
    .load_i    (load),
    .load_val_i(load_val),
    .div_i     (div_q),
    .hit_o     (hit),
    .cnt_o     (cnt_q)
  );

  baud_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .clk_out_en_i(clk_out_en_i),
    .tick_o      (tick_o),
    .baud_clk_o  (baud_clk_o)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              dlab_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ref_en_i,
  input logic              clk_out_en_i,
  input logic              tick_o,
  input logic              baud_clk_o,
  input logic [DIV_W-1:0]  div_i,
  input logic [DIV_W-1:0]  cnt_i
);
  logic wr_ok;
  assign wr_ok = wr_en_i && dlab_i && (addr_i < ADDR_W'(2));

  p_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dlab_i) |=> $stable(div_i));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != '0) |-> (cnt_i != '0 && cnt_i <= div_i));

  p_no_tick_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ($past(div_i) != '0));

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (cnt_i == div_i && !tick_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_en_i && !wr_ok) |=> $stable(cnt_i));

  p_tick_on_ref_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(ref_en_i));

  p_gate_sub_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_clk_o |-> tick_o);

  p_gate_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!clk_out_en_i) |-> !baud_clk_o);
endmodule

bind baud_gen baud_gen_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .dlab_i      (dlab_i),
  .addr_i      (addr_i),
  .ref_en_i    (ref_en_i),
  .clk_out_en_i(clk_out_en_i),
  .tick_o      (tick_o),
  .baud_clk_o  (baud_clk_o),
  .div_i       (div_q),
  .cnt_i       (cnt_q)
);

// File: tb/baud_gen_test.sv
module baud_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 80000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, dlab = 1'b0, ref_en = 1'b1, clk_out_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick, baud_clk;
  logic       ref_alt = 1'b0;
  int         n_vec = 0, n_bad = 0;

  baud_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .dlab_i(dlab),
    .addr_i(addr), .wr_data_i(wr_data), .ref_en_i(ref_en),
    .clk_out_en_i(clk_out_en), .tick_o(tick), .baud_clk_o(baud_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) ref_en <= ref_alt ? ~ref_en : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic acc);
    @(negedge clk);
    addr = a; wr_data = d; dlab = acc; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; dlab = 1'b0;
  endtask

  task automatic set_div(input int v);
    wr(3'd0, 8'(v), 1'b1);
    wr(3'd1, 8'(v >> 8), 1'b1);
  endtask

  // negedges until the next tick sample, 0 when none
  task automatic cycles_to_tick(output int k);
    k = 0;
    for (int i = 1; i <= TIMEOUT; i++) begin
      @(negedge clk);
      if (tick) begin k = i; break; end
    end
  endtask

  task automatic measure(input int exp, input string req);
    int k;
    cycles_to_tick(k);
    cycles_to_tick(k);
    check(k == exp, req, k, exp);
  endtask

  task automatic t_reset;
    int hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick || baud_clk) hits++;
    end
    check(hits == 0, "R1", hits, 0);
  endtask

  task automatic t_periods;
    set_div(12);  measure(12, "R3");
    set_div(96);  measure(96, "R3");
    set_div(2);   measure(2, "R3");
    set_div(16'h0103); measure(259, "R2");
    set_div(384); measure(384, "R3");
  endtask

  task automatic t_div_one;
    int hi = 0;
    set_div(1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tick) hi++;
    end
    check(hi == 10, "R4", hi, 10);
  endtask

  task automatic t_div_zero;
    int hits = 0;
    set_div(0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick) hits++;
    end
    check(hits == 0, "R5", hits, 0);
  endtask

  task automatic t_reload;
    int k;
    set_div(1000);
    repeat (100) @(negedge clk);
    wr(3'd0, 8'd20, 1'b1);       // divisor becomes 0x0314
    check(tick == 1'b0, "R6", tick, 0);
    cycles_to_tick(k);
    check(k == 788, "R6", k, 788);
    set_div(1);
    wr(3'd1, 8'd0, 1'b1);        // reload while counter sits at 1
    check(tick == 1'b0, "R6", tick, 0);
  endtask

  task automatic t_ref_gate;
    set_div(5);
    ref_alt = 1'b1;
    measure(10, "R7");
    ref_alt = 1'b0;
    measure(5, "R7");
  endtask

  task automatic t_clk_gate;
    int bad = 0, seen = 0;
    set_div(3);
    clk_out_en = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tick) seen++;
      if (baud_clk) bad++;
    end
    check(bad == 0 && seen > 0, "R8", bad, 0);
    clk_out_en = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (baud_clk != tick) bad++;
    end
    check(bad == 0, "R8", bad, 0);
    clk_out_en = 1'b0;
  endtask

  task automatic t_ignore;
    set_div(4);
    measure(4, "R2");
    wr(3'd0, 8'h50, 1'b0);
    measure(4, "R2");
    wr(3'd1, 8'h7f, 1'b0);
    measure(4, "R2");
    wr(3'd2, 8'h50, 1'b1);
    measure(4, "R9");
    wr(3'd7, 8'h33, 1'b1);
    measure(4, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_periods();
    t_div_one();
    t_div_zero();
    t_reload();
    t_ref_gate();
    t_clk_gate();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule